// File: doc/BRIEF.md
# Alternate-Mode Nibble-Write Bank File

This block holds the banking state for the second personality of a cartridge memory mapper. It is used when the personality's mode bit is clear. The CPU writes into a 16-bit address space at $8000-$FFFF. The block keeps its own set of registers:

- two switchable 8 KB PRG bank numbers;
- a nametable mirroring flag;
- eight 1 KB CHR bank numbers.

These registers are separate from the registers of the other personality. Whenever mode_active is low, writes have no effect and the stored values are kept for a later return to this mode.

On the read side, the block takes the CPU address bits A14..A13 and returns the PRG bank for that 8 KB window. The top 16 KB is fixed to the last two banks of the ROM. It also takes the PPU address bits A12..A10 and returns the 1 KB CHR bank for that slot. The CHR registers are loaded in 4-bit halves. The register a write lands in is chosen from scattered address bits: the 4 KB page number, offset down by three and doubled, is ORed with A11 and with A1.

Top module: `alt_bank_file`

## Requirements
- R1: After reset, every bank register and the mirroring flag are zero: CPU windows 0 and 1 map to bank 0, all eight CHR slots read 0, and mirror_h is 0.
- R2: A write with wr_addr[15:12] = 8 and wr_addr[1:0] = 00 loads wr_data into the PRG bank for CPU window 0 ($8000-$9FFF, cpu_win = 00); the output is that value modulo PRG_BANKS (a power of two).
- R3: Writes to pages 8, 9 or A whose wr_addr[1:0] is not 00 change nothing.
- R4: A write with wr_addr[15:12] = 9 and wr_addr[1:0] = 00 sets mirror_h to wr_data[0]; 0 means vertical and 1 means horizontal.
- R5: A write with wr_addr[15:12] = A and wr_addr[1:0] = 00 loads wr_data into the PRG bank for CPU window 1 ($A000-$BFFF, cpu_win = 01), modulo PRG_BANKS.
- R6: cpu_win = 10 always yields bank PRG_BANKS-2 and cpu_win = 11 always yields bank PRG_BANKS-1.
- R7: A write to pages B through E targets the CHR register ((wr_addr[14:12] - 3) * 2) OR wr_addr[11] OR wr_addr[1].
- R8: On a CHR write with wr_addr[0] = 0, bits 3:0 of the target register take wr_data[3:0] and bits 7:4 are kept. With wr_addr[0] = 1, bits 7:4 take wr_data[3:0] and bits 3:0 are kept.
- R9: chr_bank shows the CHR register whose index equals ppu_win (PPU A12..A10), so $0000-$1FFF is covered in eight 1 KB slots in order.
- R10: While mode_active is low, no write changes any register; the values are kept until the mode returns.
- R11: Writes with wr_stb low, below $8000, or in $F000-$FFFF change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_active | input | 1 | High while this banking personality is selected |
| wr_stb | input | 1 | CPU write strobe, one write per cycle |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| cpu_win | input | 2 | CPU A14..A13, selects the 8 KB PRG window |
| ppu_win | input | 3 | PPU A12..A10, selects the 1 KB CHR slot |
| prg_bank | output | PRG_W | 8 KB PRG bank for the selected CPU window |
| chr_bank | output | 8 | 1 KB CHR bank for the selected PPU slot |
| mirror_h | output | 1 | Mirroring: 0 vertical, 1 horizontal |

## Verification
The hardest case to reach is two CHR addresses that differ only in A11 and A1 and land on the same register because the index is an OR, not a sum. A related case is a half-write that must leave the other nibble untouched. Both only show up after a register already holds a non-zero value in the nibble that is not being written. The stimulus sweeps every combination of page, A11, A1 and A0 in order, so each register receives both halves from several aliased addresses. A long run of random writes then follows, with random mode and random alignment. After every write, all four CPU windows and all eight PPU slots are scanned against a behavioural model.

// File: rtl/alt_bank_pkg.sv
package alt_bank_pkg;

    localparam int BYTE_W    = 8;
    localparam int NIB_W     = 4;
    localparam int ADDR_W    = 16;
    localparam int CHR_REGS  = 8;
    localparam int CHR_IDX_W = $clog2(CHR_REGS);
    localparam int PAGE_W    = 4;

    // 4 KB page numbers (address bits 15:12) that the decoder reacts to
    localparam logic [PAGE_W-1:0] PG_PRG_LO    = 4'h8;
    localparam logic [PAGE_W-1:0] PG_MIRROR    = 4'h9;
    localparam logic [PAGE_W-1:0] PG_PRG_HI    = 4'hA;
    localparam logic [PAGE_W-1:0] PG_CHR_FIRST = 4'hB;
    localparam logic [PAGE_W-1:0] PG_CHR_LAST  = 4'hE;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_PRG_LO,
        TGT_MIRROR,
        TGT_PRG_HI,
        TGT_CHR
    } wr_target_e;

    typedef struct packed {
        wr_target_e             target;
        logic [CHR_IDX_W-1:0]   chr_idx;
        logic                   hi_half;
        logic [BYTE_W-1:0]      data;
    } wr_cmd_t;

    // Page offset by three, doubled, then ORed with A11 and A1.
    // Pages B..E give 3..6 in bits 14:12; modulo four the low two bits suffice.
    function automatic logic [CHR_IDX_W-1:0] chr_index(input logic [ADDR_W-1:0] a);
        logic [1:0] grp;
        grp = a[13:12] - 2'd3;
        return {grp, 1'b0} | {2'b00, (a[11] | a[1])};
    endfunction

    function automatic logic page_is_chr(input logic [PAGE_W-1:0] pg);
        return (pg >= PG_CHR_FIRST) && (pg <= PG_CHR_LAST);
    endfunction

endpackage

// File: rtl/alt_wr_decode.sv
module alt_wr_decode
    import alt_bank_pkg::*;
(
    input  logic              mode_active,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output wr_cmd_t           cmd
);

    logic [PAGE_W-1:0] page;
    logic              aligned;

    assign page    = wr_addr[ADDR_W-1 -: PAGE_W];
    assign aligned = (wr_addr[1:0] == 2'b00);

    always_comb begin
        cmd         = '0;
        cmd.target  = TGT_NONE;
        cmd.data    = wr_data;
        cmd.hi_half = wr_addr[0];
        cmd.chr_idx = chr_index(wr_addr);
        if (mode_active && wr_stb) begin
            if (page == PG_PRG_LO && aligned) begin
                cmd.target = TGT_PRG_LO;
            end else if (page == PG_MIRROR && aligned) begin
                cmd.target = TGT_MIRROR;
            end else if (page == PG_PRG_HI && aligned) begin
                cmd.target = TGT_PRG_HI;
            end else if (page_is_chr(page)) begin
                cmd.target = TGT_CHR;
            end
        end
    end

endmodule

// File: rtl/alt_prg_bank.sv
module alt_prg_bank
    import alt_bank_pkg::*;
#(
    parameter int PRG_BANKS = 16,
    parameter int PRG_W     = $clog2(PRG_BANKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_cmd_t           cmd,
    input  logic [1:0]        cpu_win,
    output logic [PRG_W-1:0]  prg_bank,
    output logic              mirror_h,
    output logic [BYTE_W-1:0] prg_lo_q,
    output logic [BYTE_W-1:0] prg_hi_q
);

    localparam logic [PRG_W-1:0] LAST_BANK = PRG_W'(PRG_BANKS - 1);
    localparam logic [PRG_W-1:0] NEXT_LAST = PRG_W'(PRG_BANKS - 2);

    always_ff @(posedge clk) begin
        if (rst) begin
            prg_lo_q <= '0;
            prg_hi_q <= '0;
            mirror_h <= 1'b0;
        end else begin
            unique case (cmd.target)
                TGT_PRG_LO: prg_lo_q <= cmd.data;
                TGT_PRG_HI: prg_hi_q <= cmd.data;
                TGT_MIRROR: mirror_h <= cmd.data[0];
                default: ;
            endcase
        end
    end

    // Windows 2 and 3 are fixed to the last 16 KB of the ROM
    always_comb begin
        unique case (cpu_win)
            2'b00:   prg_bank = prg_lo_q[PRG_W-1:0];
            2'b01:   prg_bank = prg_hi_q[PRG_W-1:0];
            2'b10:   prg_bank = NEXT_LAST;
            default: prg_bank = LAST_BANK;
        endcase
    end

endmodule

// File: rtl/alt_chr_file.sv
module alt_chr_file
    import alt_bank_pkg::*;
#(
    parameter int N_REGS = CHR_REGS,
    parameter int IDX_W  = $clog2(N_REGS)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  wr_cmd_t                       cmd,
    input  logic [IDX_W-1:0]              ppu_win,
    output logic [N_REGS-1:0][BYTE_W-1:0] chr_regs,
    output logic [BYTE_W-1:0]             chr_bank
);

    logic is_chr;
    assign is_chr = (cmd.target == TGT_CHR);

    for (genvar g = 0; g < N_REGS; g++) begin : g_reg
        logic hit;
        assign hit = is_chr && (cmd.chr_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                chr_regs[g] <= '0;
            end else if (hit) begin
                if (cmd.hi_half) begin
                    chr_regs[g][BYTE_W-1:NIB_W] <= cmd.data[NIB_W-1:0];
                end else begin
                    chr_regs[g][NIB_W-1:0] <= cmd.data[NIB_W-1:0];
                end
            end
        end
    end

    assign chr_bank = chr_regs[ppu_win];

endmodule

// File: rtl/alt_bank_file.sv
module alt_bank_file
    import alt_bank_pkg::*;
#(
    parameter  int PRG_BANKS = 16,
    localparam int PRG_W     = $clog2(PRG_BANKS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_active,
    input  logic             wr_stb,
    input  logic [15:0]      wr_addr,
    input  logic [7:0]       wr_data,
    input  logic [1:0]       cpu_win,
    input  logic [2:0]       ppu_win,
    output logic [PRG_W-1:0] prg_bank,
    output logic [7:0]       chr_bank,
    output logic             mirror_h
);

    wr_cmd_t                            cmd;
    logic [BYTE_W-1:0]                  prg_lo_q;
    logic [BYTE_W-1:0]                  prg_hi_q;
    logic [CHR_REGS-1:0][BYTE_W-1:0]    chr_regs;

    alt_wr_decode u_dec (
        .mode_active (mode_active),
        .wr_stb      (wr_stb),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .cmd         (cmd)
    );

    alt_prg_bank #(
        .PRG_BANKS (PRG_BANKS),
        .PRG_W     (PRG_W)
    ) u_prg (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .cpu_win  (cpu_win),
        .prg_bank (prg_bank),
        .mirror_h (mirror_h),
        .prg_lo_q (prg_lo_q),
        .prg_hi_q (prg_hi_q)
    );

    alt_chr_file #(
        .N_REGS (CHR_REGS),
        .IDX_W  (CHR_IDX_W)
    ) u_chr (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .ppu_win  (ppu_win),
        .chr_regs (chr_regs),
        .chr_bank (chr_bank)
    );

endmodule

// File: rtl/alt_bank_file_chk.sv
module alt_bank_file_chk #(
    parameter int PRG_BANKS = 16,
    parameter int PRG_W     = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             mode_active,
    input logic             wr_stb,
    input logic [15:0]      wr_addr,
    input logic [7:0]       wr_data,
    input logic [1:0]       cpu_win,
    input logic [PRG_W-1:0] prg_bank,
    input logic             mirror_h,
    input logic [7:0]       prg_lo_q,
    input logic [7:0]       prg_hi_q,
    input logic [7:0][7:0]  chr_regs
);

    logic       pend;
    logic [2:0] pend_idx;
    logic [7:0] pend_exp;
    logic       chr_wr;
    int         base;
    int         idx;

    assign chr_wr = mode_active && wr_stb &&
                    (wr_addr[15:12] >= 4'hB) && (wr_addr[15:12] <= 4'hE);

    always_comb begin
        base = (int'(wr_addr[15:12]) - 11) * 2;
        idx  = (wr_addr[11] || wr_addr[1]) ? base + 1 : base;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend     <= 1'b0;
            pend_idx <= '0;
            pend_exp <= '0;
        end else begin
            pend     <= chr_wr;
            pend_idx <= idx[2:0];
            if (wr_addr[0]) pend_exp <= {wr_data[3:0], chr_regs[idx[2:0]][3:0]};
            else            pend_exp <= {chr_regs[idx[2:0]][7:4], wr_data[3:0]};
        end
    end

    assert_prg_lo_load_R2: assert property (@(posedge clk) disable iff (rst)
        (mode_active && wr_stb && wr_addr[15:12] == 4'h8 && wr_addr[1:0] == 2'b00)
        |=> prg_lo_q == $past(wr_data));

    assert_misaligned_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wr_addr[15:12] >= 4'h8 && wr_addr[15:12] <= 4'hA && wr_addr[1:0] != 2'b00)
        |=> $stable(prg_lo_q) && $stable(prg_hi_q) && $stable(mirror_h));

    assert_mirror_load_R4: assert property (@(posedge clk) disable iff (rst)
        (mode_active && wr_stb && wr_addr[15:12] == 4'h9 && wr_addr[1:0] == 2'b00)
        |=> mirror_h == $past(wr_data[0]));

    assert_prg_hi_load_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_active && wr_stb && wr_addr[15:12] == 4'hA && wr_addr[1:0] == 2'b00)
        |=> prg_hi_q == $past(wr_data));

    assert_fixed_next_last_R6: assert property (@(posedge clk) disable iff (rst)
        (cpu_win == 2'b10) |-> prg_bank == PRG_W'(PRG_BANKS - 2));

    assert_fixed_last_R6: assert property (@(posedge clk) disable iff (rst)
        (cpu_win == 2'b11) |-> prg_bank == PRG_W'(PRG_BANKS - 1));

    assert_chr_half_write_R8: assert property (@(posedge clk) disable iff (rst)
        pend |-> chr_regs[pend_idx] == pend_exp);

    assert_inactive_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !mode_active |=> $stable(chr_regs) && $stable(prg_lo_q) &&
                         $stable(prg_hi_q) && $stable(mirror_h));

endmodule

bind alt_bank_file alt_bank_file_chk #(
    .PRG_BANKS (PRG_BANKS),
    .PRG_W     (PRG_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mode_active (mode_active),
    .wr_stb      (wr_stb),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .cpu_win     (cpu_win),
    .prg_bank    (prg_bank),
    .mirror_h    (mirror_h),
    .prg_lo_q    (prg_lo_q),
    .prg_hi_q    (prg_hi_q),
    .chr_regs    (chr_regs)
);

// File: tb/sim_alt_bank_file.sv
`timescale 1ns/10ps
module sim_alt_bank_file;

    localparam int PRG_BANKS = 16;
    localparam int PRG_W     = $clog2(PRG_BANKS);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             mode_active = 1'b1;
    logic             wr_stb = 1'b0;
    logic [15:0]      wr_addr = '0;
    logic [7:0]       wr_data = '0;
    logic [1:0]       cpu_win = '0;
    logic [2:0]       ppu_win = '0;
    logic [PRG_W-1:0] prg_bank;
    logic [7:0]       chr_bank;
    logic             mirror_h;

    always #2 clk = ~clk;

    alt_bank_file #(.PRG_BANKS(PRG_BANKS)) u0 (
        .clk(clk), .rst(rst), .mode_active(mode_active), .wr_stb(wr_stb),
        .wr_addr(wr_addr), .wr_data(wr_data), .cpu_win(cpu_win), .ppu_win(ppu_win),
        .prg_bank(prg_bank), .chr_bank(chr_bank), .mirror_h(mirror_h)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // behavioural reference state
    int m_prg0, m_prg1, m_mir;
    int m_chr [8];

    task automatic model_reset();
        m_prg0 = 0; m_prg1 = 0; m_mir = 0;
        for (int i = 0; i < 8; i++) m_chr[i] = 0;
    endtask

    task automatic model_write(input logic [15:0] a, input logic [7:0] d, input bit act, input bit stb);
        int pg;
        int idx;
        if (!act || !stb) return;
        pg = int'(a[15:12]);
        if (pg >= 8 && pg <= 10 && a[1:0] != 2'b00) return;
        if (pg == 8) m_prg0 = int'(d);
        else if (pg == 9) m_mir = int'(d[0]);
        else if (pg == 10) m_prg1 = int'(d);
        else if (pg >= 11 && pg <= 14) begin
            idx = (pg - 11) * 2;
            if (a[11] || a[1]) idx = idx + 1;
            if (a[0]) m_chr[idx] = (m_chr[idx] % 16) + (int'(d) % 16) * 16;
            else      m_chr[idx] = (m_chr[idx] / 16) * 16 + (int'(d) % 16);
        end
    endtask

    task automatic compare(input string req, input string what, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    // Sweep every CPU window and every PPU slot (combinational read side)
    task automatic scan(input string req);
        int exp_prg;
        for (int s = 0; s < 8; s++) begin
            cpu_win = s[1:0];
            ppu_win = s[2:0];
            #0.2;
            case (s % 4)
                0: exp_prg = m_prg0 % PRG_BANKS;
                1: exp_prg = m_prg1 % PRG_BANKS;
                2: exp_prg = PRG_BANKS - 2;
                default: exp_prg = PRG_BANKS - 1;
            endcase
            compare(req, "prg_bank", int'(prg_bank), exp_prg);
            compare(req, "chr_bank", int'(chr_bank), m_chr[s]);
            compare(req, "mirror_h", int'(mirror_h), m_mir);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input bit act, input bit stb);
        @(negedge clk);
        wr_addr     = a;
        wr_data     = d;
        mode_active = act;
        wr_stb      = stb;
        @(posedge clk);
        model_write(a, d, act, stb);
        @(negedge clk);
        wr_stb      = 1'b0;
        mode_active = 1'b1;
    endtask

    initial begin
        #100us;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        scan("R1");

        // R2: first PRG window
        wr(16'h8000, 8'h05, 1, 1); scan("R2");
        wr(16'h8FFC, 8'h1B, 1, 1); scan("R2");
        // R3: misaligned writes ignored
        wr(16'h8001, 8'h0A, 1, 1); scan("R3");
        wr(16'h8002, 8'h0A, 1, 1); scan("R3");
        wr(16'h8003, 8'h0A, 1, 1); scan("R3");
        wr(16'h9001, 8'h01, 1, 1); scan("R3");
        wr(16'hA002, 8'h09, 1, 1); scan("R3");
        // R4: mirroring
        wr(16'h9000, 8'h01, 1, 1); scan("R4");
        wr(16'h9FFC, 8'hFE, 1, 1); scan("R4");
        wr(16'h9004, 8'h03, 1, 1); scan("R4");
        // R5 and R6: second PRG window, fixed top
        wr(16'hA000, 8'h07, 1, 1); scan("R5");
        wr(16'hAFF8, 8'hFF, 1, 1); scan("R6");

        // R7, R8, R9: every page / A11 / A1 / A0 combination, aliased writes
        for (int pg = 11; pg <= 14; pg++) begin
            for (int k = 0; k < 8; k++) begin
                logic [15:0] a;
                a = 16'(pg << 12);
                a[11] = k[2];
                a[1]  = k[1];
                a[0]  = k[0];
                wr(a, 8'(pg * 16 + k + 1), 1, 1);
                scan("R7");
            end
        end
        wr(16'hB802, 8'h3C, 1, 1); scan("R8");
        wr(16'hE003, 8'hA5, 1, 1); scan("R9");

        // R10: writes while inactive change nothing
        wr(16'h8000, 8'h0E, 0, 1); scan("R10");
        wr(16'h9000, 8'h00, 0, 1); scan("R10");
        wr(16'hA000, 8'h02, 0, 1); scan("R10");
        wr(16'hC000, 8'h0F, 0, 1); scan("R10");
        wr(16'hD801, 8'h0F, 0, 1); scan("R10");
        wr(16'h8000, 8'h0E, 1, 1); scan("R10");

        // R11: strobe low and unmapped pages
        wr(16'hA000, 8'h0C, 1, 0); scan("R11");
        wr(16'h7000, 8'h0C, 1, 1); scan("R11");
        wr(16'h0000, 8'h0C, 1, 1); scan("R11");
        wr(16'hF000, 8'h0C, 1, 1); scan("R11");
        wr(16'hFFFF, 8'h0C, 1, 1); scan("R11");

        // random mix across all rules
        for (int n = 0; n < 400; n++) begin
            logic [15:0] a;
            a = 16'h8000 | 16'($urandom_range(0, 32767));
            wr(a, 8'($urandom), ($urandom_range(0, 3) != 0), ($urandom_range(0, 7) != 0));
            scan("R7");
        end

        // R1 again after a mid-run reset
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        model_reset();
        @(negedge clk);
        rst = 1'b0;
        scan("R1");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule